// File: doc/BRIEF.md
# Dual-Slot Instruction Sequencer

This block is the multicycle control unit of a small 16-bit processor. It fetches one instruction word at a time into an external instruction register. It then decodes that word either as a single long instruction, whose lower byte is an immediate, or as two short 8-bit instructions. The upper byte runs first. The lower byte runs after it as the shadow instruction, and then the next word is fetched.

The block reads the instruction register contents, the zero and carry flags and a memory-ready handshake. From these it drives one strobe per datapath action: clear the PC, increment the PC, load the PC from a register, load the instruction register, read memory, write memory, write the register file, update the flags, and route the immediate. It also drives a one-hot ALU operation select, a marker showing which byte is active, and the two register-select fields of the active byte. A small opcode subset is enough to cover each class of instruction: ALU, compare, memory, conditional and unconditional jumps, no-op, halt and long.

The sequencer uses eleven states: reset, fetch, decode, execute and memory for the upper byte, decode, execute and memory for the lower byte, long execute, branch and halt.

Top module: `dual_slot_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, the following cycle shows only `pcClear`. The cycle after the first edge with `rst` low is a fetch cycle, with `memRead` high.
- R2: A fetch holds `memRead` high until `memReady` is seen high. In that cycle `irLoad` and `pcInc` pulse together. The next cycle decodes the upper byte and drives no strobes.
- R3: Within a byte, bits [7:4] are the opcode, [3:2] the destination field and [1:0] the source field. The upper byte is `irWord[15:8]`. `dstSel`/`srcSel` show the fields of the upper byte while `slotLo` is low, and of the lower byte while `slotLo` is high. `slotLo` is high in the lower-byte decode, execute and memory cycles, and in a branch cycle caused by the lower byte.
- R4: Opcodes 2 to 9 are ALU operations: add, subtract, and, or, not, shift, compare, multiply. Opcode n drives `aluSel` bit n-2 in its single execute cycle, together with `flagWrite`. That cycle also asserts `regWrite`, except for compare (8).
- R5: After the upper short instruction, the lower byte gets a decode cycle and is then executed. The exception is a lower byte of 8'h00: then the next cycle is a fetch.
- R6: Opcode 15 in the upper byte is a long instruction. After its decode cycle comes one cycle with `immSel`, `regWrite` and `aluSel` bit 8 (pass), and then a fetch. The lower byte is never run as an instruction.
- R7: Opcode 10 (load) holds `memRead`, and opcode 11 (store) holds `memWrite`, until `memReady` is high. A load asserts `regWrite` in that ready cycle; a store never does.
- R8: Opcodes 12 (jump if Z), 13 (jump if C) and 14 (always) are jumps. A taken jump gives one cycle with only `pcLoad` and then a fetch. A jump that is not taken drives no strobes and execution continues.
- R9: A taken jump in the upper byte cancels the shadow instruction: the cycle after the branch cycle is a fetch.
- R10: Opcode 1 in either byte raises `halted` with every other strobe low. This lasts through any `memReady` activity until reset.
- R11: Opcode 0 executes with no strobes. Opcode 15 in the lower byte has no immediate and acts as a no-op.
- R12: At most one `aluSel` bit is high, and `memRead` and `memWrite` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irWord | input | 16 | Instruction register contents |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| memReady | input | 1 | Memory access completes this cycle |
| pcClear | output | 1 | Clear the program counter |
| pcInc | output | 1 | Increment the program counter |
| pcLoad | output | 1 | Load the PC from the source register |
| irLoad | output | 1 | Load the instruction register from the data bus |
| memRead | output | 1 | Memory read request |
| memWrite | output | 1 | Memory write request |
| regWrite | output | 1 | Write the destination register |
| flagWrite | output | 1 | Update Z and C from the ALU |
| immSel | output | 1 | Route the lower byte as an immediate operand |
| aluSel | output | 9 | One-hot ALU operation select |
| slotLo | output | 1 | The lower (shadow) byte is active |
| dstSel | output | 2 | Destination field of the active byte |
| srcSel | output | 2 | Source field of the active byte |
| halted | output | 1 | Sequencer is halted |

## Verification
The bench sweeps every upper opcode against every lower opcode and against the empty shadow byte, under all four flag combinations and with varying memory wait lengths. It compares every strobe in every cycle against a trace computed from the requirements.

The sweep targets the following corner cases:
- A lower byte of 8'h00. A sequencer that ignored it would spend an extra decode cycle.
- A long word whose lower byte happens to encode halt or a memory access. A sequencer that ran the lower byte here would stall or write.
- A taken upper jump followed by a live shadow byte. If the shadow were not cancelled, extra strobes would follow the `pcLoad` cycle.
- A compare, which must not write the register file.
- A not-taken jump under the opposite flag. A flag decoded the wrong way would load the PC.
- Halt with `memReady` toggling. A sequencer that left the halt state would show fetch strobes.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  localparam int OPC_W  = 4;
  localparam int FLD_W  = 2;
  localparam int SLOT_W = OPC_W + 2 * FLD_W;
  localparam int SLOTS  = 2;
  localparam int WORD_W = SLOTS * SLOT_W;
  localparam int ALU_N  = 9;
  localparam int ALU_PASS = ALU_N - 1;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_HALT  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ADD   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_CMP   = 4'h8;
  localparam logic [OPC_W-1:0] OPC_MUL   = 4'h9;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'hA;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'hB;
  localparam logic [OPC_W-1:0] OPC_JZ    = 4'hC;
  localparam logic [OPC_W-1:0] OPC_JC    = 4'hD;
  localparam logic [OPC_W-1:0] OPC_JMP   = 4'hE;
  localparam logic [OPC_W-1:0] OPC_LONG  = 4'hF;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH, ST_DEC_HI, ST_EXEC_HI, ST_MEM_HI,
    ST_DEC_LO, ST_EXEC_LO, ST_MEM_LO, ST_EXEC_LONG, ST_BRANCH, ST_HALT
  } seqState_t;

  typedef struct packed {
    logic isAlu;
    logic isMem;
    logic isLoad;
    logic isJump;
    logic jumpTaken;
    logic isHalt;
    logic isLong;
    logic wrReg;
    logic [ALU_N-1:0] aluOneHot;
  } slotInfo_t;

  typedef struct packed {
    logic pcClear;
    logic pcInc;
    logic pcLoad;
    logic irLoad;
    logic memRead;
    logic memWrite;
    logic regWrite;
    logic flagWrite;
    logic immSel;
    logic halted;
    logic [ALU_N-1:0] aluSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/slot_decoder.sv
`timescale 1ns/1ps
module slot_decoder
  import seq_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic             flagZ,
  input  logic             flagC,
  output slotInfo_t        info
);
  localparam logic [ALU_N-1:0] ALU_ONE = 1;

  always_comb begin
    info = '0;
    info.isAlu     = (opc >= OPC_ADD) && (opc <= OPC_MUL);
    info.wrReg     = info.isAlu && (opc != OPC_CMP);
    info.aluOneHot = info.isAlu ? (ALU_ONE << (opc - OPC_ADD)) : '0;
    info.isLoad    = (opc == OPC_LOAD);
    info.isMem     = (opc == OPC_LOAD) || (opc == OPC_STORE);
    info.isJump    = (opc == OPC_JZ) || (opc == OPC_JC) || (opc == OPC_JMP);
    info.jumpTaken = (opc == OPC_JMP) || ((opc == OPC_JZ) && flagZ) ||
                     ((opc == OPC_JC) && flagC);
    info.isHalt    = (opc == OPC_HALT);
    info.isLong    = (opc == OPC_LONG);
  end
endmodule

// File: rtl/seq_decode_path.sv
`timescale 1ns/1ps
module seq_decode_path
  import seq_pkg::*;
#(
  parameter int P_SLOT_W = SLOT_W,
  parameter int P_OPC_W  = OPC_W,
  parameter int P_FLD_W  = FLD_W
) (
  input  logic [SLOTS*P_SLOT_W-1:0] irWord,
  input  logic                      flagZ,
  input  logic                      flagC,
  input  logic                      slotLo,
  output slotInfo_t                 hiInfo,
  output slotInfo_t                 loInfo,
  output logic                      loEmpty,
  output logic [P_FLD_W-1:0]        dstSel,
  output logic [P_FLD_W-1:0]        srcSel
);
  localparam int OPC_LSB = P_SLOT_W - P_OPC_W;
  localparam int DST_LSB = P_FLD_W;

  slotInfo_t info [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slot_decoder u_dec (
      .opc  (irWord[g*P_SLOT_W + OPC_LSB +: P_OPC_W]),
      .flagZ(flagZ),
      .flagC(flagC),
      .info (info[g])
    );
  end

  assign hiInfo  = info[SLOTS-1];
  assign loInfo  = info[0];
  assign loEmpty = (irWord[P_SLOT_W-1:0] == '0);

  // field mux follows the active byte
  assign dstSel = slotLo ? irWord[DST_LSB +: P_FLD_W]
                         : irWord[P_SLOT_W + DST_LSB +: P_FLD_W];
  assign srcSel = slotLo ? irWord[0 +: P_FLD_W]
                         : irWord[P_SLOT_W +: P_FLD_W];
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         memReady,
  input  logic         loEmpty,
  input  slotInfo_t    hiInfo,
  input  slotInfo_t    loInfo,
  output ctrlStrobes_t strb,
  output logic         slotLo
);
  seqState_t state, nxt, afterHi;
  logic      brLo, brLoNxt;

  assign afterHi = loEmpty ? ST_FETCH : ST_DEC_LO;
  assign slotLo  = (state == ST_DEC_LO) || (state == ST_EXEC_LO) ||
                   (state == ST_MEM_LO) || ((state == ST_BRANCH) && brLo);

  always_comb begin
    strb    = '0;
    nxt     = state;
    brLoNxt = brLo;
    case (state)
      ST_RESET: begin
        strb.pcClear = 1'b1;
        nxt = ST_FETCH;
      end
      ST_FETCH: begin
        strb.memRead = 1'b1;
        if (memReady) begin
          strb.irLoad = 1'b1;
          strb.pcInc  = 1'b1;
          nxt = ST_DEC_HI;
        end
      end
      ST_DEC_HI: begin
        if (hiInfo.isHalt)      nxt = ST_HALT;
        else if (hiInfo.isLong) nxt = ST_EXEC_LONG;
        else if (hiInfo.isMem)  nxt = ST_MEM_HI;
        else if (hiInfo.isJump) begin
          if (hiInfo.jumpTaken) begin
            nxt = ST_BRANCH;
            brLoNxt = 1'b0;
          end else begin
            nxt = afterHi;
          end
        end else nxt = ST_EXEC_HI;
      end
      ST_EXEC_HI: begin
        strb.aluSel    = hiInfo.aluOneHot;
        strb.flagWrite = hiInfo.isAlu;
        strb.regWrite  = hiInfo.wrReg;
        nxt = afterHi;
      end
      ST_MEM_HI: begin
        strb.memRead  = hiInfo.isLoad;
        strb.memWrite = !hiInfo.isLoad;
        if (memReady) begin
          strb.regWrite = hiInfo.isLoad;
          nxt = afterHi;
        end
      end
      ST_DEC_LO: begin
        if (loInfo.isHalt)      nxt = ST_HALT;
        else if (loInfo.isLong) nxt = ST_EXEC_LO;
        else if (loInfo.isMem)  nxt = ST_MEM_LO;
        else if (loInfo.isJump) begin
          if (loInfo.jumpTaken) begin
            nxt = ST_BRANCH;
            brLoNxt = 1'b1;
          end else begin
            nxt = ST_FETCH;
          end
        end else nxt = ST_EXEC_LO;
      end
      ST_EXEC_LO: begin
        strb.aluSel    = loInfo.aluOneHot;
        strb.flagWrite = loInfo.isAlu;
        strb.regWrite  = loInfo.wrReg;
        nxt = ST_FETCH;
      end
      ST_MEM_LO: begin
        strb.memRead  = loInfo.isLoad;
        strb.memWrite = !loInfo.isLoad;
        if (memReady) begin
          strb.regWrite = loInfo.isLoad;
          nxt = ST_FETCH;
        end
      end
      ST_EXEC_LONG: begin
        strb.immSel           = 1'b1;
        strb.regWrite         = 1'b1;
        strb.aluSel[ALU_PASS] = 1'b1;
        nxt = ST_FETCH;
      end
      ST_BRANCH: begin
        strb.pcLoad = 1'b1;
        nxt = ST_FETCH;
      end
      ST_HALT: begin
        strb.halted = 1'b1;
        nxt = ST_HALT;
      end
      default: nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RESET;
      brLo  <= 1'b0;
    end else begin
      state <= nxt;
      brLo  <= brLoNxt;
    end
  end

  // R1: reset state hands over to fetch
  p_reset_to_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    strb.pcClear |=> (state == ST_FETCH));
  // R2: an unanswered request is held
  p_request_held_r2: assert property (@(posedge clk) disable iff (rst)
    (strb.memRead && !memReady) |=> strb.memRead);
  // R2: word load is followed by upper decode
  p_load_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    strb.irLoad |=> (state == ST_DEC_HI));
  // R5: empty shadow byte returns to fetch
  p_empty_shadow_r5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_EXEC_HI) && loEmpty) |=> (state == ST_FETCH));
  // R9: branch always goes straight to fetch
  p_branch_cancels_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BRANCH) |=> (state == ST_FETCH));
  // R10: halt is sticky
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    strb.halted |=> strb.halted);
  // R12: operation select is one-hot or idle
  p_alu_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.aluSel));
  // R12: never read and write together
  p_mem_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(strb.memRead && strb.memWrite));
endmodule

// File: rtl/dual_slot_sequencer.sv
`timescale 1ns/1ps
module dual_slot_sequencer
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] irWord,
  input  logic              flagZ,
  input  logic              flagC,
  input  logic              memReady,
  output logic              pcClear,
  output logic              pcInc,
  output logic              pcLoad,
  output logic              irLoad,
  output logic              memRead,
  output logic              memWrite,
  output logic              regWrite,
  output logic              flagWrite,
  output logic              immSel,
  output logic [ALU_N-1:0]  aluSel,
  output logic              slotLo,
  output logic [FLD_W-1:0]  dstSel,
  output logic [FLD_W-1:0]  srcSel,
  output logic              halted
);
  slotInfo_t    hiInfo, loInfo;
  logic         loEmpty;
  ctrlStrobes_t strb;

  seq_decode_path u_path (
    .irWord (irWord),
    .flagZ  (flagZ),
    .flagC  (flagC),
    .slotLo (slotLo),
    .hiInfo (hiInfo),
    .loInfo (loInfo),
    .loEmpty(loEmpty),
    .dstSel (dstSel),
    .srcSel (srcSel)
  );

  seq_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .memReady(memReady),
    .loEmpty (loEmpty),
    .hiInfo  (hiInfo),
    .loInfo  (loInfo),
    .strb    (strb),
    .slotLo  (slotLo)
  );

  assign pcClear   = strb.pcClear;
  assign pcInc     = strb.pcInc;
  assign pcLoad    = strb.pcLoad;
  assign irLoad    = strb.irLoad;
  assign memRead   = strb.memRead;
  assign memWrite  = strb.memWrite;
  assign regWrite  = strb.regWrite;
  assign flagWrite = strb.flagWrite;
  assign immSel    = strb.immSel;
  assign aluSel    = strb.aluSel;
  assign halted    = strb.halted;
endmodule

// File: tb/dual_slot_sequencer_test.sv
`timescale 1ns/1ps
module dual_slot_sequencer_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] irWord = '0;
  logic flagZ = 1'b0, flagC = 1'b0, memReady = 1'b0;
  logic pcClear, pcInc, pcLoad, irLoad, memRead, memWrite, regWrite, flagWrite;
  logic immSel, slotLo, halted;
  logic [8:0] aluSel;
  logic [1:0] dstSel, srcSel;

  dual_slot_sequencer uut (
    .clk(clk), .rst(rst), .irWord(irWord), .flagZ(flagZ), .flagC(flagC),
    .memReady(memReady), .pcClear(pcClear), .pcInc(pcInc), .pcLoad(pcLoad),
    .irLoad(irLoad), .memRead(memRead), .memWrite(memWrite), .regWrite(regWrite),
    .flagWrite(flagWrite), .immSel(immSel), .aluSel(aluSel), .slotLo(slotLo),
    .dstSel(dstSel), .srcSel(srcSel), .halted(halted)
  );

  always #4 clk = ~clk;

  localparam logic [10:0] F_PCCLR = 11'h400, F_PCINC = 11'h200, F_PCLD = 11'h100;
  localparam logic [10:0] F_IRLD = 11'h080, F_MRD = 11'h040, F_MWR = 11'h020;
  localparam logic [10:0] F_RW = 11'h010, F_FW = 11'h008, F_IMM = 11'h004;
  localparam logic [10:0] F_LO = 11'h002, F_HLT = 11'h001;
  localparam logic [8:0]  ALU_PASS = 9'h100;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [23:0] expVec [0:31];
  bit          expRdy [0:31];
  string       expTag [0:31];
  int          expN;
  bit          expHalt;
  string       nextTag;
  logic [7:0]  curHi, curLo;
  bit          curZ, curC;

  function automatic logic [8:0] aluOf(input int op);
    return 9'(1) << (op - 2);
  endfunction

  task automatic check(input logic [23:0] exp, input string tag);
    logic [23:0] obs;
    obs = {pcClear, pcInc, pcLoad, irLoad, memRead, memWrite, regWrite, flagWrite,
           immSel, slotLo, halted, aluSel, dstSel, srcSel};
    nChecks++;
    if (obs !== exp) begin
      nFail++;
      $display("FAIL %s word=%h z=%0b c=%0b actual=%h expected=%h", tag, irWord,
               flagZ, flagC, obs, exp);
    end
    // R12: one-hot select, exclusive memory strobes
    nChecks++;
    if ($countones(aluSel) > 1 || (memRead && memWrite)) begin
      nFail++;
      $display("FAIL R12 actual alu=%b rd=%0b wr=%0b expected onehot0 and exclusive",
               aluSel, memRead, memWrite);
    end
  endtask

  task automatic push(input logic [10:0] f, input logic [8:0] alu, input bit useLo,
                      input bit rdy, input string tag);
    logic [7:0] b;
    b = useLo ? curLo : curHi;
    expVec[expN] = {f | (useLo ? F_LO : 11'h0), alu, b[3:2], b[1:0]};
    expRdy[expN] = rdy;
    expTag[expN] = tag;
    expN++;
  endtask

  task automatic buildExp(input int fd, input int md);
    int hop, lop;
    bit goLo, taken;
    expN = 0; expHalt = 0; goLo = 0;
    hop = int'(curHi[7:4]);
    lop = int'(curLo[7:4]);
    for (int k = 0; k < fd; k++) push(F_MRD, 9'h0, 0, 0, (k == 0) ? nextTag : "R2");
    push(F_MRD | F_IRLD | F_PCINC, 9'h0, 0, 1, (fd == 0) ? nextTag : "R2");
    push(11'h0, 9'h0, 0, 0, "R3");
    nextTag = "R2";
    if (hop == 1) begin
      for (int k = 0; k < 3; k++) push(F_HLT, 9'h0, 0, 1, "R10");
      expHalt = 1;
    end else if (hop == 15) begin
      push(F_IMM | F_RW, ALU_PASS, 0, 0, "R6");
      nextTag = "R6";
    end else if (hop == 10 || hop == 11) begin
      for (int k = 0; k < md; k++) push((hop == 10) ? F_MRD : F_MWR, 9'h0, 0, 0, "R7");
      push((hop == 10) ? (F_MRD | F_RW) : F_MWR, 9'h0, 0, 1, "R7");
      goLo = 1;
    end else if (hop >= 12) begin
      taken = (hop == 14) || (hop == 12 && curZ) || (hop == 13 && curC);
      if (taken) begin
        push(F_PCLD, 9'h0, 0, 0, "R8");
        nextTag = "R9";
      end else goLo = 1;
    end else if (hop == 0) begin
      push(11'h0, 9'h0, 0, 0, "R11");
      goLo = 1;
    end else begin
      push(F_FW | ((hop != 8) ? F_RW : 11'h0), aluOf(hop), 0, 0, "R4");
      goLo = 1;
    end
    if (goLo) begin
      if (curLo == 8'h00) nextTag = "R5";
      else begin
        push(11'h0, 9'h0, 1, 0, "R5");
        if (lop == 1) begin
          for (int k = 0; k < 3; k++) push(F_HLT, 9'h0, 0, 1, "R10");
          expHalt = 1;
        end else if (lop == 10 || lop == 11) begin
          for (int k = 0; k < md; k++) push((lop == 10) ? F_MRD : F_MWR, 9'h0, 1, 0, "R7");
          push((lop == 10) ? (F_MRD | F_RW) : F_MWR, 9'h0, 1, 1, "R7");
        end else if (lop >= 12 && lop <= 14) begin
          taken = (lop == 14) || (lop == 12 && curZ) || (lop == 13 && curC);
          if (taken) push(F_PCLD, 9'h0, 1, 0, "R8");
          else nextTag = "R8";
        end else if (lop == 0 || lop == 15) begin
          push(11'h0, 9'h0, 1, 0, "R11");
        end else begin
          push(F_FW | ((lop != 8) ? F_RW : 11'h0), aluOf(lop), 1, 0, "R4");
        end
      end
    end
  endtask

  task automatic playSeq();
    for (int i = 0; i < expN; i++) begin
      @(negedge clk);
      if (i == 0) begin
        irWord = {curHi, curLo};
        flagZ = curZ;
        flagC = curC;
      end
      memReady = expRdy[i];
      #1;
      check(expVec[i], expTag[i]);
    end
  endtask

  task automatic resetAndCheck(input string tag);
    @(negedge clk);
    rst = 1'b1;
    memReady = 1'b0;
    @(negedge clk);
    #1;
    // R1: only pcClear in the reset cycle
    check({F_PCCLR, 9'h0, irWord[11:10], irWord[9:8]}, tag);
    rst = 1'b0;
    nextTag = "R1";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int idx;
    curHi = '0; curLo = '0; curZ = 0; curC = 0;
    repeat (2) @(negedge clk);
    #1;
    check({F_PCCLR, 9'h0, 4'h0}, "R1");
    rst = 1'b0;
    nextTag = "R1";
    idx = 0;
    for (int ho = 0; ho < 16; ho++) begin
      for (int li = 0; li < 17; li++) begin
        for (int fl = 0; fl < 4; fl++) begin
          curHi = {4'(ho), 2'(ho + 1), 2'(ho + 2)};
          curLo = (li == 16) ? 8'h00 : {4'(li), 2'(li + 3), 2'(li)};
          curZ = fl[0];
          curC = fl[1];
          buildExp(idx % 3, (idx + 1) % 3);
          playSeq();
          if (expHalt) resetAndCheck("R10");
          idx++;
        end
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule